// File: doc/BRIEF.md
# Readout Forwarding Controller

This block takes over the word-by-word transfer of event data from a readout-and-store unit to a remote data stack, so that the host no longer issues one instruction per word. Once the readout unit shows that it has a block waiting, the block answers each synchronisation pulse from that unit by asking for the crate data bus, doing one read, parking the word in a one-word holding register and then offering it to the remote store over a valid/accept link.

The link has no queue beyond that single word. If the store is still holding off the previous word when the next synchronisation pulse arrives, the block raises a sticky link-clog flag. This flag is separate from the readout unit's own overload reporting and shows that the hold-up is on the link side. The readout unit's shared attention line carries both "word ready" and "error" causes. The block passes only the error cause, plus its own link-clog flag, to the host interrupt.

Synchronisation pulses that arrive while a transfer is under way are counted, up to a saturating limit, and served in turn.

Top module: `readout_forwarder`

## Requirements
- R1: No bus request is raised while `blk_ready` is low. A synchronisation pulse seen while `blk_ready` is low stays pending and is served once `blk_ready` goes high.
- R2: Each `sync_req` pulse leads to exactly one completed bus read (a cycle with `bus_rd` and `bus_done` both high). Timing after the edge that samples the pulse from an idle state:
  - `bus_req` is still low after that edge.
  - `bus_req` is high after the next edge.
- R3: `bus_req` stays high from its rise until the read completes. `bus_rd` rises only after a cycle in which `bus_gnt` was high. While `bus_gnt` is held low, `bus_rd` stays low.
- R4: The word on `bus_rd_data` in the completing read cycle is presented on `lnk_data` with `lnk_valid` high. It stays unchanged, with `lnk_valid` high, until a cycle with `lnk_accept` high.
- R5: A `sync_req` sampled while `lnk_valid` is high and `lnk_accept` is low sets `link_clog` after that edge.
- R6: `link_clog` stays set until a cycle with `clog_clr` high, and drops after that edge.
- R7: While `link_clog` is set, no new bus request begins. The pulse that caused the clog is kept pending and is read after the flag is cleared.
- R8: An error on the readout unit's attention line (`ru_attn` and `ru_err` high) never sets `link_clog`.
- R9: `host_irq` is high when `ru_attn` and `ru_err` are both high, or when `link_clog` is set. A read-service attention (`ru_attn` high, `ru_err` low) alone leaves `host_irq` low.
- R10: With grant, read completion and link accept all given at once, the block moves one word every 4 clocks, and evenly spaced pulses 4 clocks apart raise no clog.
- R11: After reset `bus_req`, `bus_rd`, `lnk_valid`, `link_clog` and `host_irq` are low and no pulse is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blk_ready | input | 1 | Readout unit has a data block waiting |
| sync_req | input | 1 | One-cycle synchronisation pulse, one per word |
| bus_req | output | 1 | Request for the crate data bus |
| bus_gnt | input | 1 | Bus granted |
| bus_rd | output | 1 | Read strobe on the bus |
| bus_done | input | 1 | Read completes, data valid this cycle |
| bus_rd_data | input | DATA_W | Read data from the bus |
| lnk_valid | output | 1 | Buffered word offered on the link |
| lnk_accept | input | 1 | Remote store takes the word this cycle |
| lnk_data | output | DATA_W | Buffered word |
| ru_attn | input | 1 | Readout unit attention line |
| ru_err | input | 1 | Attention cause is an error |
| host_irq | output | 1 | Masked interrupt to the host |
| link_clog | output | 1 | Sticky link-clog flag |
| clog_clr | input | 1 | Host clears the link-clog flag |

## Verification
The bench builds the block with `DATA_W` = 16 and `PEND_W` = 2. Three pending pulses is enough headroom for every case it drives, and 16-bit words make each forwarded value distinct. The bus responder can hold back the grant, and the link sink can hold back accept. This reaches the stalled-grant wait, the held-word case, and the clog case, where a second pulse lands on an unaccepted word. Back-to-back bursts at the 4-clock rate show that the single-word buffer keeps up without raising a clog.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_BUS_REQ    = 2'd1,
    ST_BUS_READ   = 2'd2,
    ST_LINK_WRITE = 2'd3
  } fwd_state_t;

  // Saturating up/down count of pulses waiting for service.
  function automatic int unsigned pend_next(int unsigned cnt, logic inc,
                                            logic dec, int unsigned cap);
    int unsigned n;
    n = cnt;
    if (dec && n != 0) n = n - 1;
    if (inc && n < cap) n = n + 1;
    return n;
  endfunction

  // Host interrupt: errors only, read-service causes are masked.
  function automatic logic irq_merge(logic attn, logic err, logic clog);
    return (attn & err) | clog;
  endfunction

endpackage

// File: rtl/fwd_seq.sv
module fwd_seq #(
  parameter int PEND_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                blk_ready,
  input  logic                sync_req,
  input  logic                clog_hold,
  input  logic                bus_gnt,
  input  logic                bus_done,
  input  logic                lnk_accept,
  output fwd_pkg::fwd_state_t state,
  output logic                bus_req,
  output logic                bus_rd,
  output logic                start_evt,
  output logic                capture_evt,
  output logic                clog_evt
);
  import fwd_pkg::*;

  localparam int unsigned PEND_MAX = (1 << PEND_W) - 1;

  fwd_state_t        state_q, state_d;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic              grant_evt, release_evt;

  assign start_evt   = (state_q == ST_IDLE) && (pend_q != '0) && blk_ready && !clog_hold;
  assign grant_evt   = (state_q == ST_BUS_REQ) && bus_gnt;
  assign capture_evt = (state_q == ST_BUS_READ) && bus_done;
  assign release_evt = (state_q == ST_LINK_WRITE) && lnk_accept;
  assign clog_evt    = (state_q == ST_LINK_WRITE) && sync_req && !lnk_accept;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (start_evt)   state_d = ST_BUS_REQ;
      ST_BUS_REQ:    if (grant_evt)   state_d = ST_BUS_READ;
      ST_BUS_READ:   if (capture_evt) state_d = ST_LINK_WRITE;
      ST_LINK_WRITE: if (release_evt) state_d = ST_IDLE;
      default:                        state_d = ST_IDLE;
    endcase
  end

  assign pend_d = PEND_W'(pend_next(int'(pend_q), sync_req, start_evt, PEND_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign state   = state_q;
  assign bus_req = (state_q == ST_BUS_REQ) || (state_q == ST_BUS_READ);
  assign bus_rd  = (state_q == ST_BUS_READ);

  p_start_needs_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(blk_ready));

  p_one_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> !bus_rd);

  p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !capture_evt) |=> bus_req);

  p_rd_after_gnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd) |-> $past(bus_gnt));

endmodule

// File: rtl/fwd_buf.sv
module fwd_buf #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_evt,
  input  logic [DATA_W-1:0] bus_rd_data,
  input  logic              lnk_accept,
  output logic              lnk_valid,
  output logic [DATA_W-1:0] lnk_data
);

  logic              full_q;
  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      word_q <= '0;
    end else begin
      if (capture_evt) begin
        full_q <= 1'b1;
        word_q <= bus_rd_data;
      end else if (full_q && lnk_accept) begin
        full_q <= 1'b0;
      end
    end
  end

  assign lnk_valid = full_q;
  assign lnk_data  = word_q;

  p_hold_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_valid && !lnk_accept) |=> (lnk_valid && $stable(lnk_data)));

  p_capture_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> (lnk_valid && lnk_data == $past(bus_rd_data)));

endmodule

// File: rtl/fwd_irq.sv
module fwd_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic clog_evt,
  input  logic clog_clr,
  input  logic ru_attn,
  input  logic ru_err,
  output logic link_clog,
  output logic host_irq
);
  import fwd_pkg::*;

  logic clog_q;

  // A new clog event wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        clog_q <= 1'b0;
    else if (clog_evt) clog_q <= 1'b1;
    else if (clog_clr) clog_q <= 1'b0;
  end

  assign link_clog = clog_q;
  assign host_irq  = irq_merge(ru_attn, ru_err, clog_q);

  p_clog_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clog_evt |=> link_clog);

  p_clog_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (link_clog && !clog_clr) |=> link_clog);

  p_err_no_clog_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_clog && !clog_evt) |=> !link_clog);

  p_irq_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ru_attn && !ru_err && !link_clog) |-> !host_irq);

endmodule

// File: rtl/readout_forwarder.sv
module readout_forwarder #(
  parameter int DATA_W = 16,
  parameter int PEND_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_ready,
  input  logic              sync_req,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_rd,
  input  logic              bus_done,
  input  logic [DATA_W-1:0] bus_rd_data,
  output logic              lnk_valid,
  input  logic              lnk_accept,
  output logic [DATA_W-1:0] lnk_data,
  input  logic              ru_attn,
  input  logic              ru_err,
  output logic              host_irq,
  output logic              link_clog,
  input  logic              clog_clr
);
  import fwd_pkg::*;

  fwd_state_t state;
  logic       start_evt, capture_evt, clog_evt;

  fwd_seq #(.PEND_W(PEND_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .blk_ready   (blk_ready),
    .sync_req    (sync_req),
    .clog_hold   (link_clog),
    .bus_gnt     (bus_gnt),
    .bus_done    (bus_done),
    .lnk_accept  (lnk_accept),
    .state       (state),
    .bus_req     (bus_req),
    .bus_rd      (bus_rd),
    .start_evt   (start_evt),
    .capture_evt (capture_evt),
    .clog_evt    (clog_evt)
  );

  fwd_buf #(.DATA_W(DATA_W)) u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture_evt (capture_evt),
    .bus_rd_data (bus_rd_data),
    .lnk_accept  (lnk_accept),
    .lnk_valid   (lnk_valid),
    .lnk_data    (lnk_data)
  );

  fwd_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clog_evt  (clog_evt),
    .clog_clr  (clog_clr),
    .ru_attn   (ru_attn),
    .ru_err    (ru_err),
    .link_clog (link_clog),
    .host_irq  (host_irq)
  );

  p_valid_tracks_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_valid == (state == ST_LINK_WRITE));

  p_no_start_clog_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !$past(link_clog));

  p_start_leaves_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> bus_req);

endmodule

// File: tb/test_readout_forwarder.sv
module test_readout_forwarder;
  localparam int DATA_W = 16;
  localparam int PEND_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blk_ready = 1'b0, sync_req = 1'b0, clog_clr = 1'b0;
  logic ru_attn = 1'b0, ru_err = 1'b0;
  logic bus_gnt = 1'b0, bus_done = 1'b0, lnk_accept = 1'b0;
  logic [DATA_W-1:0] bus_rd_data = '0;
  logic bus_req, bus_rd, lnk_valid, host_irq, link_clog;
  logic [DATA_W-1:0] lnk_data;

  // bench controls for the bus responder and link sink
  logic gnt_en = 1'b1, done_en = 1'b1, acc_en = 1'b1;
  logic [DATA_W-1:0] next_word = 16'hA500;
  logic [DATA_W-1:0] exp_q[$];
  int reads = 0, delivered = 0, req_cycles = 0;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  readout_forwarder #(.DATA_W(DATA_W), .PEND_W(PEND_W)) i_readout_forwarder (
    .clk(clk), .rst_n(rst_n), .blk_ready(blk_ready), .sync_req(sync_req),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_rd(bus_rd), .bus_done(bus_done),
    .bus_rd_data(bus_rd_data), .lnk_valid(lnk_valid), .lnk_accept(lnk_accept),
    .lnk_data(lnk_data), .ru_attn(ru_attn), .ru_err(ru_err),
    .host_irq(host_irq), .link_clog(link_clog), .clog_clr(clog_clr));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Responder, sink and scoreboard monitor: all at the falling edge.
  always @(negedge clk) begin
    if (bus_req) req_cycles++;
    bus_gnt = bus_req && gnt_en;
    if (bus_rd && done_en) begin
      bus_done = 1'b1;
      bus_rd_data = next_word;
      exp_q.push_back(next_word);
      next_word = next_word + 16'h0101;
      reads++;
    end else begin
      bus_done = 1'b0;
    end
    lnk_accept = lnk_valid && acc_en;
    if (lnk_valid && lnk_accept) begin
      delivered++;
      if (exp_q.size() == 0) chk("R4 word without read", 1, 0);
      else chk("R4 forwarded word", int'(lnk_data), int'(exp_q.pop_front()));
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse_sync();
    sync_req = 1'b1;
    step(1);
    sync_req = 1'b0;
  endtask

  task automatic wait_valid(string req);
    int k = 0;
    while (!lnk_valid && k < 60) begin
      step(1);
      k++;
    end
    chk(req, int'(lnk_valid), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    // R11 reset state
    chk("R11 bus_req", int'(bus_req), 0);
    chk("R11 bus_rd", int'(bus_rd), 0);
    chk("R11 lnk_valid", int'(lnk_valid), 0);
    chk("R11 link_clog", int'(link_clog), 0);
    chk("R11 host_irq", int'(host_irq), 0);
    rst_n = 1'b1;
    step(2);
    chk("R11 nothing pending", req_cycles, 0);

    // R1: pulse while not ready, then ready
    pulse_sync();
    step(6);
    chk("R1 no request while not ready", req_cycles, 0);
    blk_ready = 1'b1;
    wait_valid("R1 pending pulse served");
    step(2);
    chk("R1 one read", reads, 1);
    chk("R1 delivered", delivered, 1);

    // R2 latency from idle
    step(2);
    sync_req = 1'b1;
    @(negedge clk);
    @(posedge clk); #2 sync_req = 1'b0;
    @(negedge clk);
    chk("R2 bus_req low after sampling edge", int'(bus_req), 0);
    @(negedge clk);
    chk("R2 bus_req high one edge later", int'(bus_req), 1);
    step(5);
    chk("R2 read count", reads, 2);

    // R10 burst at the 4-clock rate
    for (int i = 0; i < 8; i++) begin
      pulse_sync();
      step(3);
    end
    step(6);
    chk("R10 burst reads", reads, 10);
    chk("R10 burst delivered", delivered, 10);
    chk("R10 no clog in burst", int'(link_clog), 0);

    // R3 grant held off
    gnt_en = 1'b0;
    pulse_sync();
    step(5);
    chk("R3 request held", int'(bus_req), 1);
    chk("R3 no read before grant", int'(bus_rd), 0);
    chk("R3 no read count", reads, 10);
    gnt_en = 1'b1;
    wait_valid("R3 read after grant");
    step(2);

    // R4 word held while not accepted
    acc_en = 1'b0;
    pulse_sync();
    wait_valid("R4 word offered");
    begin
      logic [DATA_W-1:0] held;
      held = lnk_data;
      step(5);
      chk("R4 still valid", int'(lnk_valid), 1);
      chk("R4 data stable", int'(lnk_data), int'(held));
    end
    acc_en = 1'b1;
    step(3);
    chk("R4 accepted", int'(lnk_valid), 0);

    // R5/R6/R7 clog
    acc_en = 1'b0;
    pulse_sync();
    wait_valid("R5 word offered");
    pulse_sync();
    @(negedge clk);
    chk("R5 clog set", int'(link_clog), 1);
    chk("R9 irq on clog", int'(host_irq), 1);
    begin
      int rc;
      int rd0;
      rd0 = reads;
      acc_en = 1'b1;
      step(2);
      rc = req_cycles;
      step(6);
      chk("R7 no request while clogged", req_cycles, rc);
      chk("R7 no read while clogged", reads, rd0);
      chk("R6 clog sticky", int'(link_clog), 1);
      clog_clr = 1'b1;
      step(1);
      clog_clr = 1'b0;
      chk("R6 clog cleared", int'(link_clog), 0);
      wait_valid("R7 pending served after clear");
      step(2);
      chk("R7 one more read", reads, rd0 + 1);
    end

    // R8/R9 interrupt masking
    ru_attn = 1'b1; ru_err = 1'b0;
    step(1);
    chk("R9 read attention masked", int'(host_irq), 0);
    ru_err = 1'b1;
    step(1);
    chk("R9 error attention passes", int'(host_irq), 1);
    step(3);
    chk("R8 error does not set clog", int'(link_clog), 0);
    ru_attn = 1'b0; ru_err = 1'b0;
    step(1);
    chk("R9 irq low when quiet", int'(host_irq), 0);

    step(4);
    chk("R2 reads match delivered", reads, delivered);
    chk("R4 scoreboard empty", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule